// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block serialises one transmit word at a time onto a single line that rests high. A word is up to nine bits wide and is written together with a three-bit format code, a parity-sense select and a stop-count select. The format code decides what goes out after the eight body bits. It can be the top bit of the word, a parity bit the block computes itself, or an address/data marker for multi-drop links. Some formats send no ninth bit at all. One format carries seven data bits with a generated parity bit in the eighth slot.

Bit timing comes from a baud tick shared with other channels. Each bit lasts a fixed number of ticks. A one-deep holding register sits in front of the shifter, so software can queue the next word while a frame is still on the line. Two one-cycle pulses report events to an interrupt controller. One marks the moment the holding register hands its word to the shifter. The other marks the end of the last stop bit when nothing more is waiting.

Top module: `uart9_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle after that edge: `txd` is 1, `buf_free` is 1, both pulses are 0, and any queued or in-flight word is discarded.
- R2: A frame is a start bit (0), then body bits 0 to 7 LSB first, then the ninth bit if the format has one, then stop bits (1). Each bit lasts TICKS_PER_BIT cycles in which `baud_tick` is 1.
- R3: Format 3'b100 sends `wr_data[8]` as the ninth bit.
- R4: Format 3'b111 sends a ninth bit equal to the XOR of `wr_data[7:0]` when `odd_par` is 0, and to its inverse when `odd_par` is 1.
- R5: Format 3'b101 sends `wr_data[8]` as the ninth bit, 1 meaning an address frame and 0 a data frame.
- R6: Formats 3'b000, 3'b001, 3'b010 and 3'b110 send eight body bits and no ninth bit; `wr_data[8]` has no effect.
- R7: Format 3'b011 sends `wr_data[6:0]` in body bits 0 to 6. Body bit 7 carries a parity bit over `wr_data[6:0]`, with the same sense rule as R4. `wr_data[7]` and `wr_data[8]` have no effect.
- R8: `two_stop` = 1 gives two stop bits and 0 gives one.
- R9: A write (`wr_en` high) is taken only while `buf_free` is 1. It stores the word with the format, parity sense and stop count present in that cycle. A write while `buf_free` is 0 is dropped. The stored word moves into the shifter when the line is idle, or right at the end of the current frame's last stop bit, so frames follow back to back. `buf_empty_irq` pulses for one cycle as the new frame's start bit begins.
- R10: `tx_done_irq` pulses for one cycle, with `txd` high, in the cycle after the last stop bit ends. It pulses only when no word was waiting in the holding register.
- R11: While `baud_tick` is 0 and no word moves into the shifter, `txd` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | Shared bit-rate enable, one cycle per tick |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 9 | Transmit word |
| mode | input | 3 | Frame format code |
| odd_par | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, high when idle |
| buf_free | output | 1 | Holding register can accept a write |
| buf_empty_irq | output | 1 | One-cycle pulse when the queued word starts on the line |
| tx_done_irq | output | 1 | One-cycle pulse at the end of the final frame |

## Verification
The bench builds the block with TICKS_PER_BIT = 8 and holds `baud_tick` high for most runs. Every bit boundary then falls on a known cycle, and the bench can sample each bit at its middle and look at the pulses on the exact cycle a frame ends. Eight cycles per bit also leave room to queue a second word and try a third inside the first start bit, which exercises the back-to-back hand-over and the dropped write. A run with the tick held low stretches the start bit and shows that bit time follows the tick, not the clock.

// File: rtl/uart9_pkg.sv
// Shared constants and types for the nine-bit serial transmitter.
// Assumes a frame of at most 1 start + 9 data + 2 stop bits.
package uart9_pkg;

    localparam int unsigned WORD_W    = 9;
    localparam int unsigned FRAME_MAX = 12;
    localparam int unsigned LEN_W     = $clog2(FRAME_MAX + 1);

    // Format codes; the three coded formats keep their fixed encodings.
    typedef enum logic [2:0] {
        FMT_PLAIN_A = 3'b000,
        FMT_PLAIN   = 3'b001,
        FMT_PLAIN_B = 3'b010,
        FMT_SEVEN_P = 3'b011,
        FMT_NINE    = 3'b100,
        FMT_WAKE    = 3'b101,
        FMT_PLAIN_C = 3'b110,
        FMT_EIGHT_P = 3'b111
    } fmt_e;

    // One queued transmit request, captured at write time.
    typedef struct packed {
        logic [WORD_W-1:0] word;
        fmt_e              fmt;
        logic              odd;
        logic              two_stop;
    } txreq_t;

endpackage

// File: rtl/uart9_framer.sv
// Builds the complete LSB-first frame vector and its length from a request.
// Purely combinational; bits above the frame length are held at 1.
module uart9_framer
    import uart9_pkg::*;
(
    input  txreq_t                 req,
    output logic [FRAME_MAX-1:0]   frame,
    output logic [LEN_W-1:0]       frame_len
);

    logic [7:0] body;
    logic       ninth;
    logic       has_ninth;
    logic       par8;
    logic       par7;

    // Parity over eight or seven bits; odd sense inverts the XOR.
    assign par8 = (^req.word[7:0]) ^ req.odd;
    assign par7 = (^req.word[6:0]) ^ req.odd;

    // Select body contents and the ninth bit from the format code.
    always_comb begin
        body      = req.word[7:0];
        ninth     = 1'b1;
        has_ninth = 1'b0;
        unique case (req.fmt)
            FMT_NINE, FMT_WAKE: begin
                has_ninth = 1'b1;
                ninth     = req.word[8];
            end
            FMT_EIGHT_P: begin
                has_ninth = 1'b1;
                ninth     = par8;
            end
            FMT_SEVEN_P: body = {par7, req.word[6:0]};
            default: ;
        endcase
    end

    // Assemble start, body, optional ninth bit; stop bits are the 1 fill.
    always_comb begin
        frame      = '1;
        frame[0]   = 1'b0;
        frame[8:1] = body;
        if (has_ninth) frame[9] = ninth;
        frame_len  = LEN_W'(10) + LEN_W'(has_ninth) + LEN_W'(req.two_stop);
    end

endmodule

// File: rtl/uart9_bitclk.sv
// Divides the shared baud tick into bit periods of TICKS_PER_BIT ticks.
// Restart re-aligns the count so a new frame starts with a full bit.
module uart9_bitclk #(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);

    localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // Count ticks within the current bit, wrapping at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end

    assign bit_end = tick && (cnt == LAST);

endmodule

// File: rtl/uart9_shifter.sv
// Shifts a loaded frame onto the line one bit per bit_end.
// Load takes priority over a shift in the same cycle.
module uart9_shifter
    import uart9_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_MAX-1:0]  frame_in,
    input  logic [LEN_W-1:0]      len_in,
    input  logic                  bit_end,
    output logic                  txd,
    output logic                  busy,
    output logic                  last_end
);

    logic [FRAME_MAX-1:0] sreg;
    logic [LEN_W-1:0]     remain;

    // Hold the frame, the bits left, and the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '1;
            remain <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sreg   <= frame_in;
            remain <= len_in;
            busy   <= 1'b1;
        end else if (busy && bit_end) begin
            sreg   <= {1'b1, sreg[FRAME_MAX-1:1]};
            remain <= remain - LEN_W'(1);
            if (remain == LEN_W'(1)) busy <= 1'b0;
        end
    end

    assign last_end = busy && bit_end && (remain == LEN_W'(1));
    assign txd      = busy ? sreg[0] : 1'b1;

endmodule

// File: rtl/uart9_tx.sv
// Nine-bit asynchronous serial transmitter with a one-deep holding register.
// Assumes baud_tick is a single-cycle enable; settings are captured at write.
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         baud_tick,
    input  logic         wr_en,
    input  logic [8:0]   wr_data,
    input  logic [2:0]   mode,
    input  logic         odd_par,
    input  logic         two_stop,
    output logic         txd,
    output logic         buf_free,
    output logic         buf_empty_irq,
    output logic         tx_done_irq
);

    txreq_t               hold_q;
    logic                 hold_vld;
    logic                 accept;
    logic                 load;
    logic                 busy;
    logic                 last_end;
    logic                 bit_end;
    logic [FRAME_MAX-1:0] frame;
    logic [LEN_W-1:0]     frame_len;

    assign accept   = wr_en && !hold_vld;
    assign load     = hold_vld && (!busy || last_end);
    assign buf_free = !hold_vld;

    // Capture a request with its settings when the holding register is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else if (accept) begin
            hold_vld <= 1'b1;
            hold_q   <= '{word: wr_data, fmt: fmt_e'(mode), odd: odd_par, two_stop: two_stop};
        end else if (load) begin
            hold_vld <= 1'b0;
        end
    end

    // Register the two event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_empty_irq <= 1'b0;
            tx_done_irq   <= 1'b0;
        end else begin
            buf_empty_irq <= load;
            tx_done_irq   <= last_end && !hold_vld;
        end
    end

    uart9_framer i_framer (
        .req       (hold_q),
        .frame     (frame),
        .frame_len (frame_len)
    );

    uart9_bitclk #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) i_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (baud_tick),
        .bit_end (bit_end)
    );

    uart9_shifter i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame),
        .len_in   (frame_len),
        .bit_end  (bit_end),
        .txd      (txd),
        .busy     (busy),
        .last_end (last_end)
    );

endmodule

// File: rtl/uart9_tx_chk.sv
// Port-level properties of the transmitter, bound onto every instance.
// Assumes synchronous active-low reset; all checks are off while it is low.
module uart9_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_en,
    input logic buf_free,
    input logic txd,
    input logic buf_empty_irq,
    input logic tx_done_irq
);

    // R9
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_free) |=> !buf_free);

    // R9
    empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty_irq |=> !buf_empty_irq);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |=> !tx_done_irq);

    // R10
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |-> (!buf_empty_irq && txd));

    // R11
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && buf_free) |=> $stable(txd));

endmodule

bind uart9_tx uart9_tx_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .baud_tick     (baud_tick),
    .wr_en         (wr_en),
    .buf_free      (buf_free),
    .txd           (txd),
    .buf_empty_irq (buf_empty_irq),
    .tx_done_irq   (tx_done_irq)
);

// File: tb/test_uart9_tx.sv
module test_uart9_tx;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 8;
    localparam int NVEC       = 14;

    // {mode, odd_par, two_stop, wr_data}
    localparam logic [13:0] VEC [NVEC] = '{
        {3'b100, 1'b0, 1'b0, 9'h1A5},
        {3'b100, 1'b0, 1'b1, 9'h03C},
        {3'b111, 1'b0, 1'b0, 9'h0B7},
        {3'b111, 1'b0, 1'b0, 9'h007},
        {3'b111, 1'b1, 1'b1, 9'h007},
        {3'b111, 1'b1, 1'b0, 9'h0F0},
        {3'b101, 1'b0, 1'b0, 9'h142},
        {3'b101, 1'b0, 1'b1, 9'h042},
        {3'b001, 1'b0, 1'b0, 9'h1FF},
        {3'b000, 1'b0, 1'b1, 9'h155},
        {3'b110, 1'b1, 1'b0, 9'h1AA},
        {3'b011, 1'b0, 1'b0, 9'h0D3},
        {3'b011, 1'b1, 1'b1, 9'h181},
        {3'b010, 1'b0, 1'b0, 9'h00F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [2:0] mode = '0;
    logic       odd_par = 1'b0;
    logic       two_stop = 1'b0;
    logic       txd;
    logic       buf_free;
    logic       buf_empty_irq;
    logic       tx_done_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart9_tx #(.TICKS_PER_BIT(TPB)) i_uart9_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .mode(mode), .odd_par(odd_par), .two_stop(two_stop),
        .txd(txd), .buf_free(buf_free), .buf_empty_irq(buf_empty_irq),
        .tx_done_irq(tx_done_irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected frame from the requirements.
    task automatic model(input logic [2:0] m, input logic od, input logic tw,
                         input logic [8:0] w, output logic [11:0] f, output int n);
        logic [7:0] d;
        logic       nb;
        bit         nine;
        logic       p8;
        logic       p7;
        p8   = od ? ~(^w[7:0]) : (^w[7:0]);
        p7   = od ? ~(^w[6:0]) : (^w[6:0]);
        d    = w[7:0];
        nine = 1'b0;
        nb   = 1'b1;
        case (m)
            3'b100:  begin nine = 1'b1; nb = w[8]; end
            3'b101:  begin nine = 1'b1; nb = w[8]; end
            3'b111:  begin nine = 1'b1; nb = p8; end
            3'b011:  d[7] = p7;
            default: ;
        endcase
        f      = '1;
        f[0]   = 1'b0;
        f[8:1] = d;
        if (nine) f[9] = nb;
        n = 10 + int'(nine) + int'(tw);
    endtask

    function automatic string tag_of(input logic [2:0] m, input logic tw);
        string s;
        case (m)
            3'b100:  s = "R3";
            3'b111:  s = "R4";
            3'b101:  s = "R5";
            3'b011:  s = "R7";
            default: s = "R6";
        endcase
        if (tw) s = {s, " R8"};
        return {"R2 ", s};
    endfunction

    // Called at a negedge; returns one negedge later with inputs scrambled.
    task automatic send(input logic [8:0] w, input logic [2:0] m,
                        input logic od, input logic tw);
        wr_data = w; mode = m; odd_par = od; two_stop = tw; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = ~w; mode = ~m; odd_par = ~od; two_stop = ~tw;
    endtask

    // Entered in the start bit's cycle number `skip`; samples each bit mid-way.
    task automatic recv(input logic [11:0] ef, input int n, input int skip,
                        input bit exp_done, input string tag);
        logic [11:0] got;
        got = '1;
        for (int i = 0; i < n; i++) begin
            int w;
            w = (i == 0) ? (TPB/2 - skip) : TPB;
            repeat (w) @(negedge clk);
            got[i] = txd;
        end
        chk(got == ef, tag, "frame bits", 32'(got), 32'(ef));
        repeat (TPB - TPB/2) @(negedge clk);
        chk(tx_done_irq == exp_done, "R10", "done pulse at frame end",
            32'(tx_done_irq), 32'(exp_done));
    endtask

    task automatic start_seen(input string tag);
        chk(buf_free == 1'b0, "R9", "write taken", 32'(buf_free), 32'd0);
        @(negedge clk);
        chk(buf_empty_irq == 1'b1 && txd == 1'b0, tag, "start bit and empty pulse",
            32'({buf_empty_irq, txd}), 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] ef;
        int          n;
        logic [11:0] ef2;
        int          n2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd && buf_free && !buf_empty_irq && !tx_done_irq, "R1", "idle after reset",
            32'({txd, buf_free, buf_empty_irq, tx_done_irq}), 32'hC);

        // Table of formats.
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] m;
            logic       od;
            logic       tw;
            logic [8:0] w;
            {m, od, tw, w} = VEC[v];
            model(m, od, tw, w, ef, n);
            send(w, m, od, tw);
            start_seen("R2");
            recv(ef, n, 0, 1'b1, tag_of(m, tw));
            @(negedge clk);
            chk(!tx_done_irq && txd && buf_free, "R10", "single pulse, idle line",
                32'({tx_done_irq, txd, buf_free}), 32'h3);
        end

        // R9 back-to-back hand-over, dropped third write.
        model(3'b100, 1'b0, 1'b0, 9'h1A5, ef, n);
        model(3'b111, 1'b0, 1'b1, 9'h007, ef2, n2);
        send(9'h1A5, 3'b100, 1'b0, 1'b0);
        start_seen("R9");
        send(9'h007, 3'b111, 1'b0, 1'b1);
        chk(buf_free == 1'b0, "R9", "queued while busy", 32'(buf_free), 32'd0);
        send(9'h0FF, 3'b001, 1'b0, 1'b0);
        recv(ef, n, 2, 1'b0, "R9 R3");
        chk(buf_empty_irq == 1'b1 && txd == 1'b0, "R9", "next start right after stop",
            32'({buf_empty_irq, txd}), 32'h2);
        recv(ef2, n2, 0, 1'b1, "R9 R4 R8");
        for (int k = 0; k < 3*TPB; k++) begin
            @(negedge clk);
            if (!(txd && buf_free)) begin
                chk(1'b0, "R9", "dropped write stays off the line",
                    32'({txd, buf_free}), 32'h3);
                break;
            end
        end
        chk(txd && buf_free, "R9", "line idle after dropped write",
            32'({txd, buf_free}), 32'h3);

        // R11 tick held low stretches the start bit.
        baud_tick = 1'b0;
        model(3'b001, 1'b0, 1'b0, 9'h05A, ef, n);
        send(9'h05A, 3'b001, 1'b0, 1'b0);
        start_seen("R11");
        begin
            bit held;
            held = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (txd !== 1'b0) held = 1'b0;
            end
            chk(held, "R11", "start bit held without ticks", 32'(held), 32'd1);
        end
        baud_tick = 1'b1;
        recv(ef, n, 0, 1'b1, "R11");

        // R1 reset in the middle of a frame.
        send(9'h0AA, 3'b100, 1'b0, 1'b1);
        start_seen("R1");
        send(9'h033, 3'b001, 1'b0, 1'b0);
        repeat (3*TPB) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(txd && buf_free && !tx_done_irq && !buf_empty_irq, "R1", "reset mid-frame",
            32'({txd, buf_free, buf_empty_irq, tx_done_irq}), 32'hC);
        rst_n = 1'b1;
        repeat (2*TPB) @(negedge clk);
        chk(txd && buf_free, "R1", "queued word discarded by reset",
            32'({txd, buf_free}), 32'h3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule